// File: doc/BRIEF.md
# Port Expander Serial Slave

This block is the two-wire serial slave front end of an 8-bit quasi-bidirectional port expander. It runs from a fast system clock that oversamples the bus lines, recognises bus START and STOP conditions, and compares a received 7-bit address against a fixed 4-bit prefix joined to three strap inputs. It acknowledges each byte it owns by pulling the data line low through an open-drain enable.

There is no command byte and no register pointer. In a write, every acknowledged byte overwrites the single 8-bit port latch and raises a one-cycle write strobe. In a read, the port pins are captured on a one-cycle read strobe and shifted out most significant bit first. Each byte the master acknowledges is followed by a newly captured one, and the stream ends when the master does not acknowledge. Either stream may be as long as the master likes, and a repeated START may replace the STOP.

Top module: `pex_i2c_slave`

## Requirements
- R1: While reset is held, and right after it, the SDA pull enable is 0, the port latch reads 8'hFF, and neither strobe is active.
- R2: A START (SDA falls while SCL is high) restarts address reception from any state, including in the middle of a byte. A STOP (SDA rises while SCL is high) returns the slave to idle with SDA released.
- R3: The slave address is {prefix, strap[2:0]}. The prefix is 4'b0100 when PREFIX_SEL is 0 and 4'b0111 when it is 1. The address byte carries the address in bits 7..1, sent MSB first, and its bit 0 selects the operation (1 = read, 0 = write). On a match the slave holds SDA low through the ninth clock.
- R4: On a mismatched address the slave never drives SDA, raises no strobe and leaves the latch unchanged until the next START.
- R5: In a write, each data byte is acknowledged. While the acknowledge clock is high it replaces the port latch (byte bit 7 to latch bit 7, bit 0 to bit 0), with exactly one write strobe of one cycle.
- R6: Any number of data bytes may follow one write address. The byte received last is the one the latch holds.
- R7: In a read, the pins are captured with a one-cycle read strobe on the SCL falling edge that ends the address acknowledge. The captured byte is then sent MSB first.
- R8: If the master acknowledges a read byte, the pins are captured again at the end of that acknowledge clock and sent. If it does not acknowledge, the slave releases SDA and raises no further strobe.
- R9: A repeated START in place of STOP is accepted, and the new address byte's operation bit is honoured.
- R10: ack_phase_o is high during the ninth clock of every byte the slave takes part in and low during data and address bits. SDA is never driven while address bits are received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 3 | Pin-strapped low address bits |
| pins_i | input | 8 | Present logic level of the port pins |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| port_q_o | output | 8 | Port latch contents |
| wr_pulse_o | output | 1 | One-cycle strobe when the latch is written |
| rd_pulse_o | output | 1 | One-cycle strobe when the pins are captured |
| ack_phase_o | output | 1 | High during an acknowledge slot |

## Verification
On every cycle the assertions check that the strobes last one cycle and never coincide, that the latch changes only on a write strobe inside an acknowledge slot, and that SDA is free during address bits and after a STOP. They also check that a START always leads into address reception and that every entry into transmit comes with a pin capture. Only the bench's scenarios can show the rest: that the right address is acknowledged and a wrong one ignored, that bytes arrive MSB first in the latch, and that the pins are captured at the right acknowledge edge. The bench also shows the ACK and NACK endings of a read and the recovery through a START in the middle of a byte.

// File: rtl/pex_pkg.sv
package pex_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK
  } pex_state_e;

  // Fixed upper address nibble picked by the variant parameter
  function automatic logic [3:0] fixed_prefix(input int unsigned sel);
    return (sel == 0) ? 4'b0100 : 4'b0111;
  endfunction

  // Full 7-bit slave address
  function automatic logic [6:0] slave_addr(input logic [3:0] pfx, input logic [2:0] strap);
    return {pfx, strap};
  endfunction

  function automatic logic addr_hit(input logic [6:0] rx, input logic [3:0] pfx,
                                    input logic [2:0] strap);
    return rx == slave_addr(pfx, strap);
  endfunction

endpackage

// File: rtl/pex_line_sync.sv
module pex_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] sync_o,
  output logic [LINES-1:0] prev_o
);

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain;
      logic              last;
      // bus lines idle high, so reset the chain high
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain <= '1;
          last  <= 1'b1;
        end else begin
          chain <= {chain[STAGES-2:0], raw_i[g]};
          last  <= chain[STAGES-1];
        end
      end
      assign sync_o[g] = chain[STAGES-1];
      assign prev_o[g] = last;
    end
  endgenerate

endmodule

// File: rtl/pex_bus_events.sv
module pex_bus_events (
  input  logic scl_s,
  input  logic scl_p,
  input  logic sda_s,
  input  logic sda_p,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);

  logic scl_held_high;

  assign scl_held_high = scl_s & scl_p;
  assign start_o       = scl_held_high &  sda_p & ~sda_s;
  assign stop_o        = scl_held_high & ~sda_p &  sda_s;
  assign scl_rise_o    =  scl_s & ~scl_p;
  assign scl_fall_o    = ~scl_s &  scl_p;

endmodule

// File: rtl/pex_byte_engine.sv
module pex_byte_engine
  import pex_pkg::*;
#(
  parameter int unsigned PREFIX_SEL = 0,
  parameter int          BYTE_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic [BYTE_W-1:0] pins_i,
  output logic              sda_pull_o,
  output logic [BYTE_W-1:0] port_q_o,
  output logic              wr_pulse_o,
  output logic              rd_pulse_o,
  output logic              ack_phase_o,
  output logic              addr_phase_o,
  output logic              tx_phase_o
);

  localparam int          CNT_W = $clog2(BYTE_W + 1);
  localparam logic [3:0]  PFX   = fixed_prefix(PREFIX_SEL);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] TX_LAST  = CNT_W'(BYTE_W - 1);

  pex_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic              rw;
  logic              mack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      rw         <= 1'b0;
      mack       <= 1'b0;
      port_q_o   <= '1;
      wr_pulse_o <= 1'b0;
      rd_pulse_o <= 1'b0;
    end else begin
      wr_pulse_o <= 1'b0;
      rd_pulse_o <= 1'b0;
      if (start_i) begin
        state <= ST_ADDR;
        cnt   <= '0;
      end else if (stop_i) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise_i) begin
              shreg <= {shreg[BYTE_W-2:0], sda_i};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall_i && cnt == LAST_CNT) begin
              if (addr_hit(shreg[BYTE_W-1:1], PFX, strap_i)) begin
                state <= ST_AACK;
                rw    <= shreg[0];
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall_i) begin
              cnt <= '0;
              if (rw) begin
                shreg      <= pins_i;
                rd_pulse_o <= 1'b1;
                state      <= ST_RDAT;
              end else begin
                state <= ST_WDAT;
              end
            end
          end
          ST_WDAT: begin
            if (scl_rise_i) begin
              shreg <= {shreg[BYTE_W-2:0], sda_i};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall_i && cnt == LAST_CNT) begin
              state <= ST_WACK;
            end
          end
          ST_WACK: begin
            if (scl_rise_i) begin
              port_q_o   <= shreg;
              wr_pulse_o <= 1'b1;
            end else if (scl_fall_i) begin
              cnt   <= '0;
              state <= ST_WDAT;
            end
          end
          ST_RDAT: begin
            if (scl_fall_i) begin
              shreg <= {shreg[BYTE_W-2:0], 1'b1};
              if (cnt == TX_LAST) begin
                cnt   <= '0;
                state <= ST_RACK;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              mack <= ~sda_i;
            end else if (scl_fall_i) begin
              if (mack) begin
                shreg      <= pins_i;
                rd_pulse_o <= 1'b1;
                state      <= ST_RDAT;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign ack_phase_o  = (state == ST_AACK) || (state == ST_WACK) || (state == ST_RACK);
  assign addr_phase_o = (state == ST_ADDR);
  assign tx_phase_o   = (state == ST_RDAT);
  assign sda_pull_o   = (state == ST_AACK) || (state == ST_WACK) ||
                        ((state == ST_RDAT) && !shreg[BYTE_W-1]);

endmodule

// File: rtl/pex_i2c_slave.sv
module pex_i2c_slave #(
  parameter int unsigned PREFIX_SEL  = 0,
  parameter int          SYNC_STAGES = 2,
  parameter int          BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic [BYTE_W-1:0] pins_i,
  output logic              sda_pull_o,
  output logic [BYTE_W-1:0] port_q_o,
  output logic              wr_pulse_o,
  output logic              rd_pulse_o,
  output logic              ack_phase_o
);

  localparam int LINES = 2;

  logic [LINES-1:0] line_sync;
  logic [LINES-1:0] line_prev;
  logic start_det, stop_det, scl_rise, scl_fall;
  logic addr_phase, tx_phase;

  pex_line_sync #(.STAGES(SYNC_STAGES), .LINES(LINES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({sda_i, scl_i}),
    .sync_o (line_sync),
    .prev_o (line_prev)
  );

  pex_bus_events u_events (
    .scl_s      (line_sync[0]),
    .scl_p      (line_prev[0]),
    .sda_s      (line_sync[1]),
    .sda_p      (line_prev[1]),
    .start_o    (start_det),
    .stop_o     (stop_det),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall)
  );

  pex_byte_engine #(.PREFIX_SEL(PREFIX_SEL), .BYTE_W(BYTE_W)) u_engine (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_det),
    .stop_i       (stop_det),
    .scl_rise_i   (scl_rise),
    .scl_fall_i   (scl_fall),
    .sda_i        (line_sync[1]),
    .strap_i      (strap_i),
    .pins_i       (pins_i),
    .sda_pull_o   (sda_pull_o),
    .port_q_o     (port_q_o),
    .wr_pulse_o   (wr_pulse_o),
    .rd_pulse_o   (rd_pulse_o),
    .ack_phase_o  (ack_phase_o),
    .addr_phase_o (addr_phase),
    .tx_phase_o   (tx_phase)
  );

endmodule

// File: rtl/pex_i2c_checker.sv
module pex_i2c_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_pull_o,
  input logic [BYTE_W-1:0] port_q_o,
  input logic              wr_pulse_o,
  input logic              rd_pulse_o,
  input logic              ack_phase_o,
  input logic              start_det,
  input logic              stop_det,
  input logic              addr_phase,
  input logic              tx_phase
);

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse_o |=> !wr_pulse_o); // R5
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pulse_o |=> !rd_pulse_o); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_pulse_o && rd_pulse_o)); // R5
  AST_WR_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse_o |-> ack_phase_o); // R10
  AST_LATCH_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(port_q_o) |-> wr_pulse_o); // R5
  AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |-> !sda_pull_o); // R10
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull_o); // R2
  AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> addr_phase); // R2
  AST_TX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_phase) |-> rd_pulse_o); // R7

endmodule

bind pex_i2c_slave pex_i2c_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sda_pull_o  (sda_pull_o),
  .port_q_o    (port_q_o),
  .wr_pulse_o  (wr_pulse_o),
  .rd_pulse_o  (rd_pulse_o),
  .ack_phase_o (ack_phase_o),
  .start_det   (start_det),
  .stop_det    (stop_det),
  .addr_phase  (addr_phase),
  .tx_phase    (tx_phase)
);

// File: tb/pex_i2c_slave_tb.sv
module pex_i2c_slave_tb;

  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic [7:0] pins = 8'hFF;

  wire        sda_pull, wr_p, rd_p, ackph;
  wire  [7:0] port_q;
  wire        sda_bus = sda_m & ~sda_pull;

  always #5 clk = ~clk;

  pex_i2c_slave u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_bus),
    .strap_i     (strap),
    .pins_i      (pins),
    .sda_pull_o  (sda_pull),
    .port_q_o    (port_q),
    .wr_pulse_o  (wr_p),
    .rd_pulse_o  (rd_p),
    .ack_phase_o (ackph)
  );

  int n_chk = 0, n_fail = 0;
  int wr_cnt = 0, rd_cnt = 0, pull_cnt = 0;
  logic ack_seen_ph, data_seen_ph;

  always @(posedge clk) begin
    if (wr_p)     wr_cnt++;
    if (rd_p)     rd_cnt++;
    if (sda_pull) pull_cnt++;
  end

  function automatic logic [6:0] exp_addr(input logic [2:0] s);
    return {4'b0100, s};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitc(input logic b, output logic r);
    sda_m = b; wt(Q);
    scl_m = 1'b1; wt(Q);
    r = sda_bus;
    if (ackph) data_seen_ph = 1'b1;
    wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic start_c;
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic stop_c;
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) bitc(b[i], r);
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    acked = !sda_bus;
    ack_seen_ph = ackph;
    wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bitc(1'b1, r);
      b[i] = r;
    end
    bitc(!mack, r);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic       a;
    logic [7:0] d, e, lat;
    int         w0, r0, p0;
    void'($urandom(32'h5EED1));
    data_seen_ph = 1'b0;
    ack_seen_ph  = 1'b0;

    // R1: reset state
    wt(12);
    chk(sda_pull == 1'b0, "R1 sda pull in reset", sda_pull, 0);
    chk(port_q == 8'hFF, "R1 latch in reset", port_q, 8'hFF);
    chk(wr_cnt == 0 && rd_cnt == 0, "R1 strobes in reset", wr_cnt + rd_cnt, 0);
    rst_n = 1'b1; wt(4);
    chk(port_q == 8'hFF && sda_pull == 1'b0, "R1 after reset", port_q, 8'hFF);

    // R3 R5 R6: write stream
    start_c();
    send_byte({exp_addr(strap), 1'b0}, a);
    chk(a, "R3 address ack", a, 1);
    chk(ack_seen_ph, "R10 ack phase in ninth clock", ack_seen_ph, 1);
    data_seen_ph = 1'b0;
    send_byte(8'h5A, a);
    chk(a && port_q == 8'h5A && wr_cnt == 1, "R5 first write byte", port_q, 8'h5A);
    chk(!data_seen_ph, "R10 ack phase low on data bits", data_seen_ph, 0);
    send_byte(8'hC3, a);
    chk(port_q == 8'hC3, "R6 second byte", port_q, 8'hC3);
    send_byte(8'h01, a);
    chk(port_q == 8'h01, "R5 bit order", port_q, 8'h01);
    send_byte(8'h80, a);
    chk(port_q == 8'h80 && wr_cnt == 4, "R6 fourth byte", wr_cnt, 4);
    stop_c();
    chk(sda_pull == 1'b0, "R2 released after stop", sda_pull, 0);

    // R4: mismatched addresses
    w0 = wr_cnt; p0 = pull_cnt;
    start_c();
    send_byte({4'b0110, strap, 1'b0}, a);
    chk(!a, "R4 wrong prefix not acked", a, 0);
    send_byte(8'h12, a);
    chk(!a, "R4 data after mismatch not acked", a, 0);
    stop_c();
    start_c();
    send_byte({4'b0100, strap ^ 3'b001, 1'b0}, a);
    chk(!a, "R3 wrong strap not acked", a, 0);
    stop_c();
    start_c();
    send_byte({4'b0111, strap, 1'b0}, a);
    chk(!a, "R3 other prefix not acked", a, 0);
    send_byte(8'h33, a);
    stop_c();
    chk(wr_cnt == w0 && port_q == 8'h80, "R4 latch untouched", port_q, 8'h80);
    chk(pull_cnt == p0, "R4 SDA never driven", pull_cnt - p0, 0);

    // R7 R8: read stream
    pins = 8'hA7;
    r0 = rd_cnt;
    start_c();
    send_byte({exp_addr(strap), 1'b1}, a);
    chk(a && rd_cnt == r0 + 1, "R7 capture at address ack", rd_cnt - r0, 1);
    wt(2);
    pins = 8'h3C;
    recv_byte(1'b1, d);
    chk(d == 8'hA7, "R7 first read byte MSB first", d, 8'hA7);
    pins = 8'h00;
    recv_byte(1'b0, d);
    chk(d == 8'h3C, "R8 fresh byte after master ack", d, 8'h3C);
    p0 = pull_cnt; r0 = rd_cnt;
    wt(Q);
    chk(sda_pull == 1'b0, "R8 released after nack", sda_pull, 0);
    stop_c();
    chk(pull_cnt == p0 && rd_cnt == r0, "R8 nothing after nack", rd_cnt - r0, 0);

    // R9: repeated start from write to read
    start_c();
    send_byte({exp_addr(strap), 1'b0}, a);
    send_byte(8'h81, a);
    pins = 8'h96;
    start_c();
    send_byte({exp_addr(strap), 1'b1}, a);
    chk(a, "R9 repeated start address ack", a, 1);
    recv_byte(1'b0, d);
    chk(d == 8'h96 && port_q == 8'h81, "R9 read after repeated start", d, 8'h96);
    stop_c();

    // R2: START in the middle of a byte
    start_c();
    send_byte({exp_addr(strap), 1'b0}, a);
    bitc(1'b0, a); bitc(1'b1, a); bitc(1'b0, a);
    start_c();
    send_byte({exp_addr(strap), 1'b0}, a);
    chk(a, "R2 address after mid-byte start", a, 1);
    send_byte(8'h44, a);
    chk(port_q == 8'h44, "R2 write after mid-byte start", port_q, 8'h44);
    stop_c();

    // random mix
    for (int it = 0; it < 24; it++) begin
      int kind, nb;
      logic bad;
      strap = 3'($urandom);
      kind  = $urandom % 2;
      nb    = 1 + ($urandom % 4);
      bad   = ($urandom % 4) == 0;
      lat   = port_q;
      w0    = wr_cnt;
      start_c();
      send_byte({bad ? exp_addr(strap) ^ 7'h01 : exp_addr(strap), kind[0]}, a);
      chk(a == !bad, "R3 random address decision", a, !bad);
      if (bad) begin
        send_byte(8'($urandom), a);
        stop_c();
        chk(port_q == lat && wr_cnt == w0, "R4 random mismatch", port_q, lat);
      end else if (kind == 0) begin
        for (int k = 0; k < nb; k++) begin
          e = 8'($urandom);
          send_byte(e, a);
          chk(a && port_q == e, "R6 random write byte", port_q, e);
        end
        stop_c();
        chk(wr_cnt == w0 + nb, "R5 one strobe per byte", wr_cnt - w0, nb);
      end else begin
        for (int k = 0; k < nb; k++) begin
          e = pins;
          pins = 8'($urandom);
          recv_byte(k != nb - 1, d);
          chk(d == e, "R8 random read byte", d, e);
        end
        stop_c();
      end
    end

    summary();
    $finish;
  end

endmodule